// File: doc/BRIEF.md
# Strobe-to-Clock Alignment Search

This controller finds the strobe delay that lines up the strobe's rising edge with the memory clock, as that clock arrives at the memory device. While a search runs it holds the device in its alignment mode and asks for the special termination setting. At each delay setting it fires a series of strobe pulses. The device samples its own clock level on each strobe rising edge and returns that level on a single feedback line. The controller reduces each group of samples to one bit by majority vote. It then moves the delay up by one tap.

The search stops at the first tap whose voted level is 1 when the tap just before it voted 0. That tap is the rising clock edge. The controller latches the tap and reports completion. Any leading run of 1s is skipped, so a wrapped edge is never taken for the real one. If the top tap is passed without finding the edge, the controller reports an error and returns the delay to zero. The block is meant for the initialization sequence. A one-cycle start request begins a search. Another start request, given after completion, runs a fresh search from tap zero.

Top module: `wlvl_search`

## Requirements
- R1: After reset, every output is low or zero.
- R2: A start pulse in idle sets tap_out to 0 and clears done, error and locked_tap at the next clock edge. From that edge until completion, lvl_active and odt_force are both high.
- R3: After each tap is set, strobe_req stays low for exactly SETTLE_CYC cycles before the first strobe pulse at that tap.
- R4: Each tap receives exactly NSAMP strobe pulses, each one cycle long. fb_level is sampled in the cycle after each pulse.
- R5: A tap's voted bit is 1 only when strictly more than half of its NSAMP samples are 1. A tie counts as 0, and a minority of wrong samples does not change the vote.
- R6: While searching, tap_out either holds or rises by exactly one.
- R7: The search locks at the first tap that votes 1 directly after a tap that voted 0. On lock, done goes high, locked_tap and tap_out both equal that tap, error stays low, and lvl_active and odt_force go low.
- R8: Taps that vote 1 before any tap has voted 0 do not end the search.
- R9: If the highest tap is passed without a lock, error and done go high and tap_out and locked_tap return to 0.
- R10: A start pulse during a search is ignored: the tap does not restart and the result is unchanged.
- R11: done, error and locked_tap hold their values until the next accepted start.
- R12: strobe_req is never high while lvl_active is low, and error is never high without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| fb_level | input | 1 | Clock level returned by the device, captured on its strobe edge |
| tap_out | output | TAP_W | Current strobe delay tap |
| strobe_req | output | 1 | One-cycle request for a strobe pulse at the current tap |
| lvl_active | output | 1 | High while the device must stay in alignment mode |
| odt_force | output | 1 | High while the alignment termination setting is required |
| done | output | 1 | Search finished (lock or error) |
| error | output | 1 | No rising edge found across the tap range |
| locked_tap | output | TAP_W | Tap at which the rising edge was found |

## Verification
The bench builds the block with its default parameters: a 6-bit tap (64 settings), a 16-cycle settle and 4 samples per tap. With these values a full sweep that finds no edge ends within about 1,600 cycles, so the exhausted-range error paths (no edge at all, and feedback stuck at 1) can be run to completion. The sample count is even, which makes a 2-to-2 tie possible, so the rule that a tie votes 0 can be shown apart from single-sample glitch rejection.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_PULSE,
    S_CAPT,
    S_DECIDE
  } wl_state_t;
endpackage

// File: rtl/wlvl_settle.sv
module wlvl_settle #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= CW'(CYC - 1);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  a_r3_settle_bound: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == CW'(CYC - 1)));
endmodule

// File: rtl/wlvl_vote.sv
module wlvl_vote #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample_en,
  input  logic bit_in,
  output logic last,
  output logic majority
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] idx;
  logic [CW-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx  <= '0;
      ones <= '0;
    end else if (sample_en) begin
      idx  <= idx + 1'b1;
      ones <= ones + CW'(bit_in);
    end
  end

  assign last     = (idx == CW'(N - 1));
  assign majority = ({ones, 1'b0} > (CW + 1)'(N));

  a_r5_vote_bound: assert property (@(posedge clk) disable iff (rst)
    (idx <= CW'(N)) && (ones <= idx));
  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !clear) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/wlvl_search.sv
module wlvl_search
  import wlvl_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int SETTLE_CYC = 16,
  parameter int NSAMP      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             fb_level,
  output logic [TAP_W-1:0] tap_out,
  output logic             strobe_req,
  output logic             lvl_active,
  output logic             odt_force,
  output logic             done,
  output logic             error,
  output logic [TAP_W-1:0] locked_tap
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  wl_state_t st, st_nxt;
  logic      seen_zero;
  logic      settle_load, settle_done;
  logic      vote_en, vote_last, vote_bit;
  logic      hit;

  wlvl_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .load(settle_load), .expired(settle_done)
  );

  wlvl_vote #(.N(NSAMP)) u_vote (
    .clk(clk), .rst(rst), .clear(settle_load), .sample_en(vote_en),
    .bit_in(fb_level), .last(vote_last), .majority(vote_bit)
  );

  assign hit = vote_bit && seen_zero;

  always_comb begin
    st_nxt = st;
    case (st)
      S_IDLE:   if (start) st_nxt = S_SETTLE;
      S_SETTLE: if (settle_done) st_nxt = S_PULSE;
      S_PULSE:  st_nxt = S_CAPT;
      S_CAPT:   st_nxt = vote_last ? S_DECIDE : S_PULSE;
      S_DECIDE: st_nxt = (hit || tap_out == TAP_MAX) ? S_IDLE : S_SETTLE;
      default:  st_nxt = S_IDLE;
    endcase
  end

  assign settle_load = (st_nxt == S_SETTLE) && (st != S_SETTLE);
  assign vote_en     = (st == S_CAPT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      tap_out    <= '0;
      locked_tap <= '0;
      seen_zero  <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
      strobe_req <= 1'b0;
      lvl_active <= 1'b0;
      odt_force  <= 1'b0;
    end else begin
      st         <= st_nxt;
      strobe_req <= (st_nxt == S_PULSE);
      lvl_active <= (st_nxt != S_IDLE);
      odt_force  <= (st_nxt != S_IDLE);
      case (st)
        S_IDLE: if (start) begin
          tap_out    <= '0;
          locked_tap <= '0;
          seen_zero  <= 1'b0;
          done       <= 1'b0;
          error      <= 1'b0;
        end
        S_DECIDE: begin
          if (!vote_bit) seen_zero <= 1'b1;
          if (hit) begin
            done       <= 1'b1;
            locked_tap <= tap_out;
          end else if (tap_out == TAP_MAX) begin
            done       <= 1'b1;
            error      <= 1'b1;
            tap_out    <= '0;
            locked_tap <= '0;
          end else begin
            tap_out <= tap_out + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r12_strobe_in_search: assert property (@(posedge clk) disable iff (rst)
    strobe_req |-> lvl_active);
  a_r12_error_has_done: assert property (@(posedge clk) disable iff (rst)
    error |-> done);
  a_r7_done_not_active: assert property (@(posedge clk) disable iff (rst)
    done |-> !lvl_active && !odt_force);
  a_r9_error_zero_tap: assert property (@(posedge clk) disable iff (rst)
    error |-> (tap_out == '0) && (locked_tap == '0));
  a_r6_tap_step: assert property (@(posedge clk) disable iff (rst)
    (lvl_active && $past(lvl_active) && !$rose(done)) |->
      (tap_out == $past(tap_out) || tap_out == $past(tap_out) + 1'b1));
  a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(locked_tap) && $stable(error));
endmodule

// File: tb/wlvl_search_test.sv
module wlvl_search_test;
  localparam int TAP_W = 6;
  localparam int NTAP  = 1 << TAP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic fb_level;
  logic [TAP_W-1:0] tap_out, locked_tap;
  logic strobe_req, lvl_active, odt_force, done, error;

  int total = 0;
  int bad = 0;

  // device model: level is 1 below one_until and from edge_tap on
  int one_until = 0;
  int edge_tap = 10;
  int g_tap = -1;
  logic [7:0] g_mask = '0;
  int cur_idx = 0;
  int per_tap_cnt = 0;
  int strobes_at [NTAP];
  int settle_meas = -1;
  int zcount = 0;
  bit armed = 0;
  int stray_strobe = 0;
  logic [TAP_W-1:0] prev_tap = '0;

  always #4 clk = ~clk;

  wlvl_search uut (
    .clk(clk), .rst(rst), .start(start), .fb_level(fb_level),
    .tap_out(tap_out), .strobe_req(strobe_req), .lvl_active(lvl_active),
    .odt_force(odt_force), .done(done), .error(error), .locked_tap(locked_tap)
  );

  always_comb begin
    fb_level = ((int'(tap_out) < one_until) || (int'(tap_out) >= edge_tap))
               ^ ((int'(tap_out) == g_tap) && g_mask[cur_idx[2:0]]);
  end

  always @(negedge clk) begin
    if (start || tap_out != prev_tap) per_tap_cnt = 0;
    if (tap_out != prev_tap) begin
      zcount = 1;
      armed  = 1;
    end else if (armed && !strobe_req) begin
      zcount++;
    end
    if (strobe_req) begin
      if (armed) begin
        settle_meas = zcount;
        armed = 0;
      end
      cur_idx = per_tap_cnt;
      per_tap_cnt++;
      strobes_at[tap_out]++;
      if (!lvl_active) stray_strobe++;
    end
    prev_tap = tap_out;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    foreach (strobes_at[i]) strobes_at[i] = 0;
    settle_meas = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, int'(done), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tap_out == 0 && locked_tap == 0, "R1 taps", int'(tap_out), 0);
    chk(!strobe_req && !lvl_active && !odt_force, "R1 controls",
        int'({strobe_req, lvl_active, odt_force}), 0);
    chk(!done && !error, "R1 status", int'({done, error}), 0);
  endtask

  task automatic t_plain();
    one_until = 0; edge_tap = 10; g_tap = -1; clear_counts();
    pulse_start();
    chk(tap_out == 0 && lvl_active && odt_force && !done, "R2 search begins",
        int'({lvl_active, odt_force, done}), 6);
    wait_done("R7 done");
    chk(locked_tap == 10, "R7 locked_tap", int'(locked_tap), 10);
    chk(tap_out == 10, "R7 tap_out", int'(tap_out), 10);
    chk(!error && !lvl_active && !odt_force, "R7 flags",
        int'({error, lvl_active, odt_force}), 0);
    chk(settle_meas == 16, "R3 settle cycles", settle_meas, 16);
    chk(strobes_at[3] == 4, "R4 pulses per tap", strobes_at[3], 4);
    chk(strobes_at[10] == 4, "R4 pulses at lock tap", strobes_at[10], 4);
    chk(strobes_at[11] == 0, "R6 no tap past lock", strobes_at[11], 0);
    repeat (20) @(negedge clk);
    chk(done && locked_tap == 10 && !error, "R11 result held", int'(locked_tap), 10);
  endtask

  task automatic t_noise();
    one_until = 0; edge_tap = 12; g_tap = 5; g_mask = 8'b0000_0100;
    pulse_start();
    wait_done("R5 glitch done");
    chk(locked_tap == 12, "R5 single glitch rejected", int'(locked_tap), 12);
    g_mask = 8'b0000_0101;
    pulse_start();
    wait_done("R5 tie done");
    chk(locked_tap == 12, "R5 tie votes zero", int'(locked_tap), 12);
    g_tap = 12; g_mask = 8'b0000_0010;
    pulse_start();
    wait_done("R5 low glitch done");
    chk(locked_tap == 12, "R5 minority zero at edge", int'(locked_tap), 12);
    g_tap = -1;
  endtask

  task automatic t_leading_ones();
    one_until = 4; edge_tap = 15; g_tap = -1;
    pulse_start();
    wait_done("R8 done");
    chk(locked_tap == 15 && !error, "R8 leading ones skipped", int'(locked_tap), 15);
    one_until = 0;
  endtask

  task automatic t_no_edge();
    one_until = 0; edge_tap = NTAP + 1;
    pulse_start();
    wait_done("R9 done");
    chk(error, "R9 error", int'(error), 1);
    chk(tap_out == 0 && locked_tap == 0, "R9 taps zero", int'(tap_out), 0);
    one_until = NTAP + 1;
    pulse_start();
    wait_done("R9 stuck high done");
    chk(error && tap_out == 0, "R9 stuck high error", int'(error), 1);
    one_until = 0;
  endtask

  task automatic t_busy_start();
    int n = 0;
    edge_tap = 20;
    pulse_start();
    while (tap_out != 5 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(tap_out >= 5 && lvl_active && !done, "R10 start ignored", int'(tap_out), 5);
    wait_done("R10 done");
    chk(locked_tap == 20, "R10 result unchanged", int'(locked_tap), 20);
  endtask

  task automatic t_restart();
    edge_tap = 7;
    pulse_start();
    chk(!done && !error && tap_out == 0 && locked_tap == 0 && lvl_active,
        "R2 restart clears", int'({done, error, lvl_active}), 1);
    wait_done("R2 restart done");
    chk(locked_tap == 7, "R2 restart lock", int'(locked_tap), 7);
    chk(stray_strobe == 0, "R12 strobe only while active", stray_strobe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (strobes_at[i]) strobes_at[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_noise();
    t_leading_ones();
    t_no_edge();
    t_busy_start();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule